// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Demultiplexer

This block sits next to a processor whose low address byte shares its pins with an 8-bit data bus. A latch-enable strobe marks the address phase. While the strobe is high, the block passes the shared byte, the dedicated upper address byte and the cycle status lines straight through. When the strobe falls, it holds all of them. The rest of the chip therefore sees a steady 16-bit address and cycle type for the whole transfer, even after the shared pins have moved on to carry data.

During the data phase, the block watches the active-low read and write strobes. It keeps the value on the shared pins from the last clock in which a strobe was active. When the strobe is released, it emits one transaction record and a one-clock completion pulse. The record holds the address, the status, the data byte and a write flag. If a new address phase begins before the open cycle has completed, a sticky protocol-error flag is set.

All inputs are taken as synchronous to `clk`. Reset is active low and synchronous.

Top module: `mxbus_demux`

## Requirements
- R1: While `ale_i` is 1, `addr_o` equals `{a_hi_i, ad_i}` and `status_o` equals `st_i` in the same cycle, with no register in between.
- R2: While `ale_i` is 0, `addr_o` and `status_o` hold the values sampled at the last clock edge at which `ale_i` was 1, whatever `ad_i`, `a_hi_i` and `st_i` do. The status bit order is: bit 0 = S0, bit 1 = S1, bit 2 = memory/IO select.
- R3: `rec_data_o` carries the `ad_i` value present at the last clock edge at which a strobe was active (`rd_n_i` or `wr_n_i` at 0) while `ale_i` was 0.
- R4: `done_o` is 1 for exactly one clock. It rises after the first clock edge at which an active strobe, seen at the previous edge, is seen released.
- R5: When `done_o` rises, `rec_addr_o` and `rec_status_o` equal the latched address and status of that cycle. `rec_wr_o` is 1 if `wr_n_i` was 0 at the last active-strobe edge. All record outputs hold until the next `done_o`.
- R6: Strobe activity while `ale_i` is 1 is ignored: it neither samples data nor completes a cycle.
- R7: Strobe pulses after a cycle has completed, and before the next `ale_i` rise, produce no `done_o` and leave the record unchanged.
- R8: A rise of `ale_i` while a cycle is open (an `ale_i` rise seen and no completion since) sets `err_o`. `err_o` then stays 1 until reset.
- R9: After reset: `done_o`=0, `err_o`=0, every record output is 0, and the latched address and status are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ale_i | input | 1 | Address latch enable strobe |
| ad_i | input | 8 | Shared low-address / data byte |
| a_hi_i | input | 8 | Dedicated upper address byte |
| st_i | input | 3 | Cycle status: S0, S1, memory/IO select |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| addr_o | output | 16 | Transparent-then-held 16-bit address |
| status_o | output | 3 | Transparent-then-held cycle status |
| done_o | output | 1 | One-clock cycle-complete pulse |
| rec_addr_o | output | 16 | Address of the last completed cycle |
| rec_status_o | output | 3 | Status of the last completed cycle |
| rec_data_o | output | 8 | Data byte of the last completed cycle |
| rec_wr_o | output | 1 | 1 if the last completed cycle was a write |
| err_o | output | 1 | Sticky protocol-error flag |

## Verification
The assertions check four properties on every cycle:
- the latched address does not move while the latch enable is low;
- the completion pulse never lasts two clocks and never appears without an open cycle;
- no completion is accepted while the latch enable is high;
- the record and the error flag change only as permitted.

Some behaviour only the bench scenarios can show. These are the actual values: which data byte is kept when the strobe stays active across several clocks, the address and status carried in the record, and the exact clock in which the pulse appears. The bench sweeps many addresses, status codes, data bytes, strobe kinds and strobe lengths. It also drives strobes inside the address phase and after completion, and a back-to-back latch pulse.

// File: rtl/mxbus_pkg.sv
package mxbus_pkg;
    localparam int unsigned ST_S0  = 0;
    localparam int unsigned ST_S1  = 1;
    localparam int unsigned ST_IOM = 2;

    function automatic logic strobe_active(input logic rd_n, input logic wr_n);
        return (~rd_n) | (~wr_n);
    endfunction
endpackage

// File: rtl/mxbus_addr_latch.sv
module mxbus_addr_latch #(
    parameter int unsigned DW = 8,
    parameter int unsigned HW = 8,
    parameter int unsigned SW = 3,
    localparam int unsigned AW = DW + HW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ale_i,
    input  logic [DW-1:0] ad_i,
    input  logic [HW-1:0] a_hi_i,
    input  logic [SW-1:0] st_i,
    output logic [AW-1:0] addr_o,
    output logic [SW-1:0] status_o,
    output logic [AW-1:0] held_addr_o,
    output logic [SW-1:0] held_st_o
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [SW-1:0] st;
    } lat_t;

    lat_t lat_d, lat_q;
    logic [AW-1:0] live_addr;

    always_comb begin
        live_addr = {a_hi_i, ad_i};
        lat_d     = lat_q;
        if (ale_i) begin
            lat_d.addr = live_addr;
            lat_d.st   = st_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign addr_o      = ale_i ? live_addr : lat_q.addr;
    assign status_o    = ale_i ? st_i      : lat_q.st;
    assign held_addr_o = lat_q.addr;
    assign held_st_o   = lat_q.st;

    a_r2_hold_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ale_i) |-> ($stable(lat_q.addr) && $stable(lat_q.st)));
endmodule

// File: rtl/mxbus_cycle_ctrl.sv
module mxbus_cycle_ctrl
    import mxbus_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ale_i,
    input  logic rd_n_i,
    input  logic wr_n_i,
    output logic sample_en_o,
    output logic finish_o,
    output logic busy_o,
    output logic err_o
);
    typedef struct packed {
        logic ale;
        logic strb;
        logic busy;
        logic err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic ale_rise, act_g, finish;

    always_comb begin
        ale_rise  = ale_i & ~ctl_q.ale;
        act_g     = strobe_active(rd_n_i, wr_n_i) & ~ale_i;
        finish    = ctl_q.busy & ctl_q.strb & ~act_g & ~ale_i;
        ctl_d     = ctl_q;
        ctl_d.ale = ale_i;
        ctl_d.strb = act_g;
        if (ale_rise)    ctl_d.busy = 1'b1;
        else if (finish) ctl_d.busy = 1'b0;
        ctl_d.err = ctl_q.err | (ale_rise & ctl_q.busy);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign sample_en_o = act_g;
    assign finish_o    = finish;
    assign busy_o      = ctl_q.busy;
    assign err_o       = ctl_q.err;

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.err |=> ctl_q.err);
    a_r6_no_finish_in_ale: assert property (@(posedge clk) disable iff (!rst_n)
        ale_i |-> !finish_o);
endmodule

// File: rtl/mxbus_data_capture.sv
module mxbus_data_capture #(
    parameter int unsigned DW = 8,
    parameter int unsigned HW = 8,
    parameter int unsigned SW = 3,
    localparam int unsigned AW = DW + HW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ad_i,
    input  logic          wr_n_i,
    input  logic          sample_en_i,
    input  logic          finish_i,
    input  logic [AW-1:0] held_addr_i,
    input  logic [SW-1:0] held_st_i,
    output logic          done_o,
    output logic [AW-1:0] rec_addr_o,
    output logic [SW-1:0] rec_status_o,
    output logic [DW-1:0] rec_data_o,
    output logic          rec_wr_o
);
    typedef struct packed {
        logic [DW-1:0] smp;
        logic          smp_wr;
        logic          done;
        logic [AW-1:0] addr;
        logic [SW-1:0] st;
        logic [DW-1:0] data;
        logic          wr;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.done = finish_i;
        if (sample_en_i) begin
            cap_d.smp    = ad_i;
            cap_d.smp_wr = ~wr_n_i;
        end
        if (finish_i) begin
            cap_d.addr = held_addr_i;
            cap_d.st   = held_st_i;
            cap_d.data = cap_q.smp;
            cap_d.wr   = cap_q.smp_wr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign done_o       = cap_q.done;
    assign rec_addr_o   = cap_q.addr;
    assign rec_status_o = cap_q.st;
    assign rec_data_o   = cap_q.data;
    assign rec_wr_o     = cap_q.wr;

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cap_q.done |=> !cap_q.done);
    a_r5_rec_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_q.done |-> ($stable(cap_q.addr) && $stable(cap_q.st)
                         && $stable(cap_q.data) && $stable(cap_q.wr)));
endmodule

// File: rtl/mxbus_demux.sv
module mxbus_demux #(
    parameter int unsigned DW = 8,
    parameter int unsigned HW = 8,
    parameter int unsigned SW = 3,
    localparam int unsigned AW = DW + HW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ale_i,
    input  logic [DW-1:0] ad_i,
    input  logic [HW-1:0] a_hi_i,
    input  logic [SW-1:0] st_i,
    input  logic          rd_n_i,
    input  logic          wr_n_i,
    output logic [AW-1:0] addr_o,
    output logic [SW-1:0] status_o,
    output logic          done_o,
    output logic [AW-1:0] rec_addr_o,
    output logic [SW-1:0] rec_status_o,
    output logic [DW-1:0] rec_data_o,
    output logic          rec_wr_o,
    output logic          err_o
);
    logic [AW-1:0] held_addr;
    logic [SW-1:0] held_st;
    logic sample_en, finish, busy;

    mxbus_addr_latch #(.DW(DW), .HW(HW), .SW(SW)) u_latch (
        .clk(clk), .rst_n(rst_n), .ale_i(ale_i), .ad_i(ad_i), .a_hi_i(a_hi_i),
        .st_i(st_i), .addr_o(addr_o), .status_o(status_o),
        .held_addr_o(held_addr), .held_st_o(held_st)
    );

    mxbus_cycle_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ale_i(ale_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i),
        .sample_en_o(sample_en), .finish_o(finish), .busy_o(busy), .err_o(err_o)
    );

    mxbus_data_capture #(.DW(DW), .HW(HW), .SW(SW)) u_cap (
        .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .wr_n_i(wr_n_i),
        .sample_en_i(sample_en), .finish_i(finish),
        .held_addr_i(held_addr), .held_st_i(held_st),
        .done_o(done_o), .rec_addr_o(rec_addr_o), .rec_status_o(rec_status_o),
        .rec_data_o(rec_data_o), .rec_wr_o(rec_wr_o)
    );

    a_r7_done_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy));
endmodule

// File: tb/tb_mxbus_demux.sv
module tb_mxbus_demux;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ale_i = 1'b0;
    logic [7:0] ad_i = '0, a_hi_i = '0;
    logic [2:0] st_i = '0;
    logic rd_n_i = 1'b1, wr_n_i = 1'b1;
    logic [15:0] addr_o, rec_addr_o;
    logic [2:0] status_o, rec_status_o;
    logic [7:0] rec_data_o;
    logic done_o, rec_wr_o, err_o;

    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mxbus_demux dut (
        .clk(clk), .rst_n(rst_n), .ale_i(ale_i), .ad_i(ad_i), .a_hi_i(a_hi_i),
        .st_i(st_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .addr_o(addr_o),
        .status_o(status_o), .done_o(done_o), .rec_addr_o(rec_addr_o),
        .rec_status_o(rec_status_o), .rec_data_o(rec_data_o), .rec_wr_o(rec_wr_o),
        .err_o(err_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    // full bus cycle; checks R1..R5 along the way
    task automatic bus_cycle(input logic [15:0] a, input logic [2:0] s,
                             input logic [7:0] d, input bit wr, input int n_act);
        step; ale_i = 1; ad_i = a[7:0]; a_hi_i = a[15:8]; st_i = s; rd_n_i = 1; wr_n_i = 1;
        #1 chk("R1 addr", addr_o, a); chk("R1 status", status_o, s);
        step; ale_i = 0; ad_i = ~a[7:0]; a_hi_i = ~a[15:8]; st_i = ~s;
        #1 chk("R2 addr", addr_o, a); chk("R2 status", status_o, s);
        for (int k = 0; k < n_act; k++) begin
            step; ad_i = (k == n_act - 1) ? d : d ^ 8'h5a;
            rd_n_i = wr; wr_n_i = !wr;
            #1 chk("R4 no early done", done_o, 0);
        end
        step; rd_n_i = 1; wr_n_i = 1; ad_i = ~d;
        #1 chk("R4 not yet", done_o, 0); chk("R2 held in data", addr_o, a);
        step;
        #1 chk("R4 done", done_o, 1); chk("R5 addr", rec_addr_o, a);
        chk("R5 status", rec_status_o, s); chk("R3 data", rec_data_o, d);
        chk("R5 wr", rec_wr_o, wr);
        step;
        #1 chk("R4 one clock", done_o, 0); chk("R5 hold", rec_data_o, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) step;
        rst_n = 1;
        #1 chk("R9 done", done_o, 0); chk("R9 err", err_o, 0);
        chk("R9 addr", addr_o, 0); chk("R9 status", status_o, 0);
        chk("R9 rec addr", rec_addr_o, 0); chk("R9 rec data", rec_data_o, 0);
        chk("R9 rec status", rec_status_o, 0); chk("R9 rec wr", rec_wr_o, 0);

        // sweep addresses, status codes, data, strobe kind and length
        for (int i = 0; i < 48; i++) begin
            bus_cycle(16'(i * 16'h1357 + 16'h00a5), 3'(i % 8), 8'(i * 29 + 3),
                      i[0], 1 + (i % 3));
            chk("R8 no error", err_o, 0);
        end

        // R6: strobe inside a two-clock address phase is ignored
        step; ale_i = 1; ad_i = 8'h11; a_hi_i = 8'h22; st_i = 3'd5; rd_n_i = 0;
        step; ad_i = 8'h33; a_hi_i = 8'h44; rd_n_i = 1;
        #1 chk("R1 follows live", addr_o, 16'h4433);
        step; ale_i = 0; ad_i = 8'h99;
        for (int k = 0; k < 3; k++) begin
            step; #1 chk("R6 no done", done_o, 0);
        end
        chk("R2 last ale value", addr_o, 16'h4433);
        step; ad_i = 8'hc3; wr_n_i = 0;
        step; wr_n_i = 1;
        step; #1 chk("R6 real done", done_o, 1); chk("R6 data", rec_data_o, 8'hc3);
        chk("R5 wr flag", rec_wr_o, 1); chk("R5 status", rec_status_o, 3'd5);

        // R7: strobes after completion are ignored
        step; ad_i = 8'h77; rd_n_i = 0;
        step;
        step; rd_n_i = 1;
        for (int k = 0; k < 3; k++) begin
            step; #1 chk("R7 no done", done_o, 0);
        end
        chk("R7 rec data kept", rec_data_o, 8'hc3);
        chk("R7 rec addr kept", rec_addr_o, 16'h4433);

        // R8: new address phase while cycle open
        step; ale_i = 1; ad_i = 8'h01; a_hi_i = 8'h02;
        step; ale_i = 0;
        step; #1 chk("R8 open ok", err_o, 0);
        step; ale_i = 1; ad_i = 8'h03;
        step; ale_i = 0;
        #1 chk("R8 err set", err_o, 1);
        bus_cycle(16'hbeef, 3'd6, 8'h42, 1'b0, 2);
        chk("R8 sticky", err_o, 1);
        step; rst_n = 0;
        step; rst_n = 1;
        #1 chk("R9 err cleared", err_o, 0); chk("R9 rec cleared", rec_addr_o, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule